// File: doc/BRIEF.md
# Transport Stream Stuffing Packet Detector

This block sits after a channel decoder and watches a byte stream of fixed-length transport stream packets. For each complete packet it decides whether the packet is a stuffing packet, one the multiplexer inserted only to hold a constant bit rate. The decision has to hold up when the decoder output still carries residual errors. Two independent rules are therefore evaluated, and either one is enough: the 13-bit packet identifier in the header equals the stuffing value, or nearly all payload bytes are zero, within a configurable tolerance.

Bytes arrive with a valid strobe, and a start-of-packet marker flags the first byte of each packet. One cycle after the last byte of a packet is accepted, the block pulses a verdict together with a reason code and the number of non-zero payload bytes. A packet cut short by a new start marker is dropped, and the block signals this with an abort pulse.

Top module: `ts_null_detector`

## Requirements
- R1: After synchronous reset, out_valid, out_abort and out_null are low and stay low until a packet completes or is cut short.
- R2: A packet is 188 accepted bytes (4 header bytes, 184 payload bytes). Only cycles with in_valid high count, so idle gaps are allowed. out_valid is a single-cycle pulse in the cycle after the 188th byte is accepted.
- R3: The identifier is header byte 1 bits [4:0] as the upper 5 bits, followed by all of header byte 2. A value of 0x1FFF sets reason bit 0. Bits [7:5] of byte 1 have no effect.
- R4: out_nonzero reports how many of the 184 payload bytes (byte indices 4 to 187) were not 0x00. Header bytes are never counted.
- R5: Reason bit 1 (zero-fill rule) is set exactly when out_nonzero is at most MAX_NONZERO (default 18). At 19 it is clear.
- R6: out_null is high when either rule matched. out_reason is 2'b00 for neither rule, 2'b01 for identifier only, 2'b10 for zero-fill only, and 2'b11 for both.
- R7: A start marker arriving while a packet is partly received causes a one-cycle out_abort pulse in the following cycle. The partial packet produces no verdict, and the marked byte becomes byte 0 of a new packet.
- R8: Bytes with in_valid low, and valid bytes arriving before any start marker, are ignored. They produce no verdict or abort and do not shift packet framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_sop | input | 1 | Marks the first byte of a packet (qualified by in_valid) |
| in_byte | input | 8 | Data byte |
| out_valid | output | 1 | One-cycle verdict strobe |
| out_null | output | 1 | Packet judged to be stuffing |
| out_reason | output | 2 | Bit 0 identifier match, bit 1 zero-fill match |
| out_nonzero | output | 8 | Count of non-zero payload bytes |
| out_abort | output | 1 | One-cycle pulse when a partial packet is dropped |

## Verification
A wrong byte position counter shows up at the ports immediately as a verdict pulse one or more cycles off from the 188th accepted byte. It can also show up as an identifier read from the wrong bytes, which flips reason bit 0 for the identifier-corrupted cases. A non-zero accumulator that is not cleared at the start of a packet carries counts over from a preceding data packet or a dropped partial packet, so out_nonzero and reason bit 1 are wrong on the very next verdict. The 18 and 19 corruption cases expose an off-by-one in the tolerance compare within a single packet.

// File: rtl/tsnd_pkg.sv
package tsnd_pkg;
  typedef enum logic [1:0] {
    RSN_NONE = 2'b00,
    RSN_PID  = 2'b01,
    RSN_ZERO = 2'b10,
    RSN_BOTH = 2'b11
  } reason_t;
endpackage

// File: rtl/tsnd_framer.sv
module tsnd_framer #(
  parameter int PKT_LEN = 188,
  localparam int CNT_W = $clog2(PKT_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  output logic             take,
  output logic [CNT_W-1:0] idx,
  output logic             last,
  output logic             abort_req
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_LEN - 1);

  logic             active;
  logic [CNT_W-1:0] pos;

  assign take      = in_valid && (in_sop || active);
  assign idx       = in_sop ? '0 : pos;
  assign last      = take && (idx == LAST_IDX);
  assign abort_req = in_valid && in_sop && active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pos    <= '0;
    end else if (take) begin
      if (last) begin
        active <= 1'b0;
        pos    <= '0;
      end else begin
        active <= 1'b1;
        pos    <= idx + CNT_W'(1);
      end
    end
  end

  // R2: completing a packet always leaves the framer idle
  assert_idle_after_last_R2: assert property (@(posedge clk) disable iff (rst)
    last |=> !active);
  // R2: position never leaves the packet range
  assert_pos_range_R2: assert property (@(posedge clk) disable iff (rst)
    active |-> (pos <= LAST_IDX));
  // R7: a dropped packet restarts framing with the marked byte
  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> (active && pos == CNT_W'(1)));
endmodule

// File: rtl/tsnd_pid_match.sv
module tsnd_pid_match #(
  parameter int          PKT_LEN  = 188,
  parameter int          PID_W    = 13,
  parameter logic [12:0] NULL_PID = 13'h1FFF,
  localparam int CNT_W = $clog2(PKT_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       in_byte,
  output logic             pid_hit
);
  localparam logic [15:0] PID_MASK = 16'((1 << PID_W) - 1);

  logic [15:0] hdr_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_sr <= '0;
    end else if (take && (idx == CNT_W'(1) || idx == CNT_W'(2))) begin
      hdr_sr <= {hdr_sr[7:0], in_byte};
    end
  end

  assign pid_hit = ((hdr_sr & PID_MASK) == 16'(NULL_PID));
endmodule

// File: rtl/tsnd_zero_count.sv
module tsnd_zero_count #(
  parameter int PKT_LEN = 188,
  parameter int HDR_LEN = 4,
  localparam int CNT_W   = $clog2(PKT_LEN),
  localparam int PAY_LEN = PKT_LEN - HDR_LEN,
  localparam int NZ_W    = $clog2(PAY_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       in_byte,
  output logic [NZ_W-1:0]  total
);
  logic [NZ_W-1:0] acc;
  logic            in_pay;
  logic            first;

  assign in_pay = (idx >= CNT_W'(HDR_LEN));
  assign first  = (idx == CNT_W'(HDR_LEN));
  assign total  = (first ? '0 : acc) + NZ_W'(in_byte != 8'h00);

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (take && in_pay) acc <= total;
  end

  // R4: accumulator cannot exceed the payload length
  assert_acc_bound_R4: assert property (@(posedge clk) disable iff (rst)
    acc <= NZ_W'(PAY_LEN));
endmodule

// File: rtl/ts_null_detector.sv
module ts_null_detector #(
  parameter int          PKT_LEN     = 188,
  parameter int          HDR_LEN     = 4,
  parameter int          PID_W       = 13,
  parameter logic [12:0] NULL_PID    = 13'h1FFF,
  parameter int          MAX_NONZERO = 18,
  localparam int CNT_W   = $clog2(PKT_LEN),
  localparam int PAY_LEN = PKT_LEN - HDR_LEN,
  localparam int NZ_W    = $clog2(PAY_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_sop,
  input  logic [7:0]      in_byte,
  output logic            out_valid,
  output logic            out_null,
  output logic [1:0]      out_reason,
  output logic [NZ_W-1:0] out_nonzero,
  output logic            out_abort
);
  import tsnd_pkg::*;

  logic             take, last, abort_req, pid_hit, zero_ok;
  logic [CNT_W-1:0] idx;
  logic [NZ_W-1:0]  total;
  reason_t          rsn;

  tsnd_framer #(.PKT_LEN(PKT_LEN)) u_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .take(take), .idx(idx), .last(last), .abort_req(abort_req)
  );

  tsnd_pid_match #(.PKT_LEN(PKT_LEN), .PID_W(PID_W), .NULL_PID(NULL_PID)) u_pid (
    .clk(clk), .rst(rst), .take(take), .idx(idx), .in_byte(in_byte),
    .pid_hit(pid_hit)
  );

  tsnd_zero_count #(.PKT_LEN(PKT_LEN), .HDR_LEN(HDR_LEN)) u_zero (
    .clk(clk), .rst(rst), .take(take), .idx(idx), .in_byte(in_byte),
    .total(total)
  );

  assign zero_ok = (total <= NZ_W'(MAX_NONZERO));
  assign rsn     = reason_t'({zero_ok, pid_hit});

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_abort   <= 1'b0;
      out_null    <= 1'b0;
      out_reason  <= RSN_NONE;
      out_nonzero <= '0;
    end else begin
      out_valid <= last;
      out_abort <= abort_req;
      if (last) begin
        out_null    <= (rsn != RSN_NONE);
        out_reason  <= rsn;
        out_nonzero <= total;
      end
    end
  end

  // R2: verdict strobe lasts one cycle
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R7: a drop and a verdict never coincide
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_abort));
  // R4: reported count fits the payload
  assert_nz_bound_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_nonzero <= NZ_W'(PAY_LEN)));
  // R5: zero-fill reason only within tolerance
  assert_zero_rule_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_reason[1]) |-> (out_nonzero <= NZ_W'(MAX_NONZERO)));
endmodule

// File: tb/test_ts_null_detector.sv
`timescale 1ns/1ps
module test_ts_null_detector;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_sop = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid, out_null, out_abort;
  logic [1:0] out_reason;
  logic [7:0] out_nonzero;

  int checks = 0, errors = 0;
  int cyc = 0, drive_cyc = 0;
  int n_valid = 0, n_abort = 0, valid_cyc = 0, abort_cyc = 0;
  logic       last_null;
  logic [1:0] last_reason;
  logic [7:0] last_nz;

  always #2.5 clk = ~clk;

  ts_null_detector i_ts_null_detector (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_byte(in_byte),
    .out_valid(out_valid), .out_null(out_null), .out_reason(out_reason),
    .out_nonzero(out_nonzero), .out_abort(out_abort)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        n_valid++; valid_cyc = cyc;
        last_null = out_null; last_reason = out_reason; last_nz = out_nonzero;
      end
      if (out_abort) begin n_abort++; abort_cyc = cyc; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic sop);
    @(negedge clk);
    in_valid = 1'b1; in_sop = sop; in_byte = b; drive_cyc = cyc;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); in_valid = 1'b0; in_sop = 1'b0; in_byte = 8'hFF;
    end
  endtask

  // Sends the first n bytes of a packet; payload positions 4..(4+nz-1) non-zero
  task automatic send_bytes(input logic [12:0] pid, input logic [2:0] flags,
                            input int nz, input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      if (i == 0)      b = 8'h47;
      else if (i == 1) b = {flags, pid[12:8]};
      else if (i == 2) b = pid[7:0];
      else if (i == 3) b = 8'h10;
      else             b = (i - 4 < nz) ? (8'h80 | 8'(i)) : 8'h00;
      send_byte(b, i == 0);
      if (gaps && (i % 7 == 3)) idle(2);
    end
  endtask

  task automatic run_packet(input string tag, input logic [12:0] pid,
                            input logic [2:0] flags, input int nz, input bit gaps);
    int v0, a0, last_drive;
    logic [1:0] er;
    v0 = n_valid; a0 = n_abort;
    send_bytes(pid, flags, nz, 188, gaps);
    last_drive = drive_cyc;
    idle(2);
    #1;
    er = {(nz <= 18), (pid == 13'h1FFF)};
    chk(n_valid - v0 == 1, {tag, " R2 one verdict"}, n_valid - v0, 1);
    chk(valid_cyc == last_drive + 1, {tag, " R2 verdict timing"}, valid_cyc, last_drive + 1);
    chk(n_abort == a0, {tag, " R7 no abort"}, n_abort - a0, 0);
    chk(last_nz == 8'(nz), {tag, " R4 nonzero count"}, last_nz, nz);
    chk(last_reason == er, {tag, " R3/R5 reason"}, last_reason, er);
    chk(last_null == (er != 2'b00), {tag, " R6 null flag"}, last_null, er != 2'b00);
  endtask

  task automatic t_reset;
    #1;
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(out_abort == 0, "R1 out_abort after reset", out_abort, 0);
    chk(out_null == 0, "R1 out_null after reset", out_null, 0);
  endtask

  task automatic t_stray;
    int v0, a0;
    v0 = n_valid; a0 = n_abort;
    for (int i = 0; i < 30; i++) send_byte(8'h00, 1'b0);
    idle(3);
    #1;
    chk(n_valid == v0, "R8 stray bytes no verdict", n_valid - v0, 0);
    chk(n_abort == a0, "R8 stray bytes no abort", n_abort - a0, 0);
  endtask

  task automatic t_early_sop;
    int v0, a0, sop_drive, last_drive;
    v0 = n_valid; a0 = n_abort;
    send_bytes(13'h0100, 3'b000, 184, 60, 1'b0);
    send_bytes(13'h1FFF, 3'b000, 0, 1, 1'b0);
    sop_drive = drive_cyc;
    send_bytes(13'h1FFF, 3'b000, 0, 0, 1'b0);
    for (int i = 1; i < 188; i++) begin
      logic [7:0] b;
      b = (i == 1) ? 8'h1F : (i == 2) ? 8'hFF : (i == 3) ? 8'h10 : 8'h00;
      send_byte(b, 1'b0);
    end
    last_drive = drive_cyc;
    idle(2);
    #1;
    chk(n_abort - a0 == 1, "R7 abort pulse", n_abort - a0, 1);
    chk(abort_cyc == sop_drive + 1, "R7 abort timing", abort_cyc, sop_drive + 1);
    chk(n_valid - v0 == 1, "R7 partial gives no verdict", n_valid - v0, 1);
    chk(valid_cyc == last_drive + 1, "R7 restart framing", valid_cyc, last_drive + 1);
    chk(last_nz == 0, "R7 count restarted", last_nz, 0);
    chk(last_reason == 2'b11, "R7 verdict of restarted packet", last_reason, 3);
  endtask

  bit done = 0;

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_stray();
    run_packet("clean null", 13'h1FFF, 3'b000, 0, 1'b0);
    run_packet("pid corrupt", 13'h1F7F, 3'b000, 5, 1'b0);
    run_packet("null 18 bad", 13'h1FFF, 3'b000, 18, 1'b0);
    run_packet("pid bad 18", 13'h0FFF, 3'b000, 18, 1'b0);
    run_packet("pid bad 19", 13'h0FFF, 3'b000, 19, 1'b0);
    run_packet("null 19 bad", 13'h1FFF, 3'b000, 19, 1'b0);
    run_packet("data", 13'h0100, 3'b000, 184, 1'b0);
    run_packet("flags set", 13'h1FFF, 3'b111, 40, 1'b0);
    run_packet("gapped", 13'h1FFF, 3'b010, 3, 1'b1);
    t_early_sop();
    run_packet("after data", 13'h0042, 3'b000, 0, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule